// File: doc/BRIEF.md
# Page Programming Buffer and Cycle Timer

This block sits behind the serial command decoder of a small serial EEPROM model. When a write command begins, the decoder supplies a start address. The data bytes that follow are collected one by one into a page-sized latch. Each byte goes to the slot given by the low address bits. Those bits then advance and wrap inside the same page, so a long burst overwrites earlier slots and never spills into the next page. The block does the same job for a status-register write, where the last byte received is the value to store.

The load ends with a chip-select rising event. A commit happens only if that event lands on a byte boundary, at least one byte has arrived and the protection logic grants permission. On a commit the block starts a self-timed programming cycle. The length of that cycle is a parameter counted in system clocks. During the cycle the block copies each slot that was actually loaded into the array, one strobe per slot, in ascending address order, or it issues a single status-register strobe. It raises the busy flag for the whole cycle. While the flag is set, new commands, bytes and chip-select events are ignored. A chip-select event that does not qualify for a commit throws the loaded bytes away.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, `wip`, `arr_we` and `sr_we` are all 0.
- R2: With `cmd_status`=0, the k-th byte after `cmd_start` (counting from 0) is written to address {start_addr[ADDR_W-1:4], (start_addr[3:0]+k) mod 16}.
- R3: When the in-page offset passes 15 it returns to 0 of the same page. A later byte that lands on a slot already loaded replaces the earlier byte.
- R4: Only loaded slots are written. A commit produces exactly one `arr_we` pulse per distinct loaded slot, and no other array address is touched.
- R5: A commit needs `cs_rise` together with `on_boundary`=1, `permit`=1 and at least one loaded byte. If any of these is missing, no strobe is issued and `wip` stays 0.
- R6: After a commit, `wip` goes to 1 in the clock that follows the one in which `cs_rise` is sampled. It stays at 1 for exactly PROG_CYCLES clocks.
- R7: Array strobes occur only while `wip`=1 and within its first PAGE_BYTES+1 clocks, with addresses strictly ascending.
- R8: While `wip`=1, `cmd_start`, `byte_valid` and `cs_rise` have no effect. `wip` does not restart, and no bytes from that period are written.
- R9: `permit` is sampled only at the commit. Dropping it during the cycle neither shortens the cycle nor removes any strobe.
- R10: With `cmd_status`=1, a commit gives exactly one `sr_we` pulse carrying the last byte loaded, and no `arr_we` pulse.
- R11: A load that ends without a commit is discarded. A later command writes only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pulse: a write command begins loading |
| cmd_status | input | 1 | With cmd_start: 1 selects status-register write, 0 array write |
| start_addr | input | ADDR_W | With cmd_start: first byte address |
| byte_valid | input | 1 | Pulse: byte_data holds a complete received byte |
| byte_data | input | 8 | Received data byte |
| on_boundary | input | 1 | With cs_rise: the bit count is on a whole byte |
| cs_rise | input | 1 | Pulse: chip select went inactive |
| permit | input | 1 | With cs_rise: protection logic allows this write |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status-register write strobe |
| sr_wdata | output | 8 | Status-register write value |
| wip | output | 1 | Programming cycle in progress |

## Verification
Every output is registered. Assume `cs_rise` is sampled at clock edge E. Then `wip` is set after E and cleared after E+PROG_CYCLES. The strobe for page slot i follows edge E+1+i, and the status strobe follows E+1. The bench drives inputs on falling edges and samples outputs on falling edges. It counts the falling edges at which `wip` is high and matches that count against PROG_CYCLES. For each strobe it records the index of its falling edge within the busy period and checks that the index falls in the window the slot order allows. Array writes are captured into a shadow memory and compared with contents predicted from the requirements, only after the cycle has fully ended.

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_status,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              on_boundary,
  input  logic              cs_rise,
  input  logic              permit,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              sr_we,
  output logic [7:0]        sr_wdata,
  output logic              wip
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic                    loading, kind_sr, have_byte;
  logic [ADDR_W-OFF_W-1:0] page_base;
  logic [OFF_W-1:0]        wr_off;
  logic [PAGE_BYTES-1:0]   mask;
  logic [7:0]              latch [PAGE_BYTES];
  logic [7:0]              last_byte;
  logic [CNT_W-1:0]        cnt;
  logic [OFF_W-1:0]        slot;
  logic                    commit, in_scan;

  assign commit  = loading & cs_rise & on_boundary & have_byte & permit;
  assign slot    = cnt[OFF_W-1:0];
  assign in_scan = cnt < CNT_W'(PAGE_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading   <= 1'b0;
      kind_sr   <= 1'b0;
      have_byte <= 1'b0;
      page_base <= '0;
      wr_off    <= '0;
      mask      <= '0;
      last_byte <= '0;
      cnt       <= '0;
      wip       <= 1'b0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
      sr_we     <= 1'b0;
      sr_wdata  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) latch[i] <= '0;
    end else begin
      arr_we <= 1'b0;
      sr_we  <= 1'b0;
      if (wip) begin
        if (in_scan && !kind_sr && mask[slot]) begin
          arr_we    <= 1'b1;
          arr_addr  <= {page_base, slot};
          arr_wdata <= latch[slot];
        end
        if (cnt == '0 && kind_sr) begin
          sr_we    <= 1'b1;
          sr_wdata <= last_byte;
        end
        if (cnt == CNT_W'(PROG_CYCLES - 1)) wip <= 1'b0;
        cnt <= cnt + 1'b1;
      end else if (commit) begin
        wip     <= 1'b1;
        cnt     <= '0;
        loading <= 1'b0;
      end else if (cmd_start) begin
        loading   <= 1'b1;
        kind_sr   <= cmd_status;
        page_base <= start_addr[ADDR_W-1:OFF_W];
        wr_off    <= start_addr[OFF_W-1:0];
        mask      <= '0;
        have_byte <= 1'b0;
      end else if (loading && cs_rise) begin
        loading <= 1'b0;
      end else if (loading && byte_valid) begin
        latch[wr_off] <= byte_data;
        mask[wr_off]  <= 1'b1;
        wr_off        <= wr_off + 1'b1;
        last_byte     <= byte_data;
        have_byte     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_prog_checker.sv
module page_prog_checker #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              on_boundary,
  input logic              permit,
  input logic              wip,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              sr_we
);
  localparam int RUN_W = $clog2(PROG_CYCLES + 1) + 1;
  logic [RUN_W-1:0] run;

  initial begin
    p_cfg_r6: assert (PROG_CYCLES > PAGE_BYTES)
      else $error("programming cycle shorter than page scan");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run <= '0;
    else if (wip) run <= run + 1'b1;
    else          run <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !wip && !arr_we && !sr_we);
  p_commit_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise && on_boundary && permit));
  p_wip_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> run == RUN_W'(PROG_CYCLES));
  p_strobe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wip && run <= RUN_W'(PAGE_BYTES));
  p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && $past(arr_we) |-> arr_addr > $past(arr_addr));
  p_no_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && sr_we));
  p_sr_in_wip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> wip);
endmodule

bind page_prog_buffer page_prog_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .on_boundary(on_boundary),
  .permit(permit), .wip(wip), .arr_we(arr_we), .arr_addr(arr_addr), .sr_we(sr_we)
);

// File: tb/test_page_prog_buffer.sv
module test_page_prog_buffer;
  localparam int AW   = 9;
  localparam int PG   = 16;
  localparam int PROG = 40;
  localparam int MEM  = 1 << AW;

  typedef struct packed {
    logic [AW-1:0] start;
    logic [5:0]    n;
    logic [7:0]    seed;
    logic          bnd;
    logic          perm;
    logic          kind;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{9'h000, 6'd1,  8'h11, 1'b1, 1'b1, 1'b0},
    '{9'h023, 6'd5,  8'h20, 1'b1, 1'b1, 1'b0},
    '{9'h1FC, 6'd8,  8'h40, 1'b1, 1'b1, 1'b0},
    '{9'h045, 6'd20, 8'h60, 1'b1, 1'b1, 1'b0},
    '{9'h080, 6'd3,  8'h90, 1'b0, 1'b1, 1'b0},
    '{9'h090, 6'd3,  8'hA0, 1'b1, 1'b0, 1'b0},
    '{9'h0A0, 6'd0,  8'hB0, 1'b1, 1'b1, 1'b0},
    '{9'h000, 6'd2,  8'hC5, 1'b1, 1'b1, 1'b1},
    '{9'h10F, 6'd16, 8'hD0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_status = 0, byte_valid = 0, on_boundary = 0, cs_rise = 0, permit = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic arr_we, sr_we, wip;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, sr_wdata;

  int tests = 0, fails = 0;
  int wip_cnt, wip_idx, wip_rises, arr_cnt, sr_cnt, bad_win, bad_order, last_addr;
  logic [7:0] sr_val;
  logic prev_wip;
  logic [7:0] got_d [MEM];
  logic       got_v [MEM];
  logic [7:0] exp_d [MEM];
  logic       exp_v [MEM];

  always #4 clk = ~clk;

  page_prog_buffer #(.ADDR_W(AW), .PAGE_BYTES(PG), .PROG_CYCLES(PROG)) i_page_prog_buffer (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_status(cmd_status),
    .start_addr(start_addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .on_boundary(on_boundary), .cs_rise(cs_rise), .permit(permit),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .wip(wip));

  always @(negedge clk) begin
    if (wip) begin
      wip_cnt++;
      wip_idx++;
      if (!prev_wip) wip_rises++;
    end else wip_idx = 0;
    prev_wip = wip;
    if (arr_we) begin
      arr_cnt++;
      got_v[arr_addr] = 1'b1;
      got_d[arr_addr] = arr_wdata;
      if (!wip || wip_idx > PG + 1) bad_win++;
      if (int'(arr_addr) <= last_addr) bad_order++;
      last_addr = int'(arr_addr);
    end
    if (sr_we) begin
      sr_cnt++;
      sr_val = sr_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_obs();
    wip_cnt = 0; wip_rises = 0; arr_cnt = 0; sr_cnt = 0; bad_win = 0; bad_order = 0;
    last_addr = -1; sr_val = '0;
    for (int a = 0; a < MEM; a++) begin
      got_v[a] = 0; got_d[a] = '0; exp_v[a] = 0; exp_d[a] = '0;
    end
  endtask

  task automatic load(input logic [AW-1:0] sa, input int n, input logic [7:0] seed, input logic kind);
    @(negedge clk);
    cmd_start = 1; start_addr = sa; cmd_status = kind;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_start = 0; byte_valid = 1; byte_data = seed + 8'(i);
    end
    @(negedge clk);
    cmd_start = 0; byte_valid = 0;
  endtask

  task automatic close(input logic bnd, input logic perm);
    cs_rise = 1; on_boundary = bnd; permit = perm;
    @(negedge clk);
    cs_rise = 0; on_boundary = 0; permit = 0;
  endtask

  task automatic predict(input logic [AW-1:0] sa, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      int a;
      a = int'({sa[AW-1:4], 4'((sa[3:0] + i) % 16)});
      exp_v[a] = 1'b1;
      exp_d[a] = seed + 8'(i);
    end
  endtask

  function automatic int mem_mismatch();
    int m = 0;
    for (int a = 0; a < MEM; a++)
      if (got_v[a] != exp_v[a] || (exp_v[a] && got_d[a] != exp_d[a])) m++;
    return m;
  endfunction

  function automatic int exp_count(input int n);
    return (n > PG) ? PG : n;
  endfunction

  initial begin
    clear_obs();
    prev_wip = 0; wip_idx = 0;
    repeat (3) @(negedge clk);
    chk(wip === 1'b0 && arr_we === 1'b0 && sr_we === 1'b0, "R1", "outputs in reset", int'(wip), 0);
    rst_n = 1;
    @(negedge clk);
    chk(wip === 1'b0 && arr_we === 1'b0, "R1", "outputs after reset", int'(wip), 0);

    for (int v = 0; v < 9; v++) begin
      bit do_commit;
      clear_obs();
      do_commit = VECS[v].n != 0 && VECS[v].bnd && VECS[v].perm;
      load(VECS[v].start, int'(VECS[v].n), VECS[v].seed, VECS[v].kind);
      close(VECS[v].bnd, VECS[v].perm);
      repeat (PROG + 6) @(negedge clk);
      if (do_commit && !VECS[v].kind) predict(VECS[v].start, int'(VECS[v].n), VECS[v].seed);
      chk(wip_cnt == (do_commit ? PROG : 0), "R6 R5 R9", "busy clocks", wip_cnt, do_commit ? PROG : 0);
      chk(mem_mismatch() == 0, "R2 R3 R4", "array contents", mem_mismatch(), 0);
      chk(arr_cnt == ((do_commit && !VECS[v].kind) ? exp_count(int'(VECS[v].n)) : 0),
          "R4", "array strobe count", arr_cnt,
          (do_commit && !VECS[v].kind) ? exp_count(int'(VECS[v].n)) : 0);
      chk(bad_win == 0 && bad_order == 0, "R7", "strobe window/order", bad_win + bad_order, 0);
      if (VECS[v].kind) begin
        chk(sr_cnt == 1, "R10", "status strobes", sr_cnt, 1);
        chk(sr_val == VECS[v].seed + 8'(VECS[v].n - 1), "R10", "status value",
            int'(sr_val), int'(VECS[v].seed + 8'(VECS[v].n - 1)));
      end else begin
        chk(sr_cnt == 0, "R10", "no status strobe", sr_cnt, 0);
      end
    end

    // R8 R9: traffic during the cycle is ignored
    clear_obs();
    load(9'h050, 3, 8'h31, 1'b0);
    close(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    load(9'h063, 2, 8'h77, 1'b0);
    close(1'b1, 1'b1);
    repeat (PROG + 6) @(negedge clk);
    predict(9'h050, 3, 8'h31);
    chk(wip_rises == 1, "R8", "busy restarts", wip_rises, 1);
    chk(wip_cnt == PROG, "R8 R9", "busy clocks", wip_cnt, PROG);
    chk(mem_mismatch() == 0, "R8", "array contents", mem_mismatch(), 0);
    chk(arr_cnt == 3, "R8", "array strobe count", arr_cnt, 3);

    // R11: aborted load leaves nothing behind
    clear_obs();
    load(9'h0B0, 4, 8'h55, 1'b0);
    close(1'b0, 1'b1);
    load(9'h0B8, 1, 8'hE1, 1'b0);
    close(1'b1, 1'b1);
    repeat (PROG + 6) @(negedge clk);
    predict(9'h0B8, 1, 8'hE1);
    chk(mem_mismatch() == 0, "R11", "array contents", mem_mismatch(), 0);
    chk(arr_cnt == 1, "R11", "array strobe count", arr_cnt, 1);
    chk(wip === 1'b0, "R6", "idle after cycle", int'(wip), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule